// File: doc/BRIEF.md
# Dual-Mode Signed Adder-Subtractor

This block adds or subtracts two signed operands in a single combinational datapath. The datapath is a ripple chain of full adders. One control input chooses between addition and subtraction, and a mode input chooses between two's-complement and one's-complement arithmetic. For subtraction, every bit of the second operand passes through an XOR gate driven by the subtract line. In two's-complement mode the subtract line also supplies the carry into bit 0, so the chain computes A + ~B + 1.

In one's-complement mode the chain's carry-in stays at zero. A second, increment-only ripple chain then adds the first chain's carry-out back in at bit 0. This end-around carry never passes through a feedback path, so the block has no combinational loop. The overflow flag compares the sign of the result with the signs of the two effective operands. The same comparison serves both modes.

The block has no clock, so its outputs follow its inputs after the gate delay. It is meant to sit inside a wider arithmetic path wherever a small signed add or subtract is needed under either number system.

Top module: `addsub_dual`

## Requirements
- R1: With ones_i=0 and sub_i=0, res_o equals (opa_i + opb_i) mod 2^WIDTH.
- R2: With ones_i=0 and sub_i=1, res_o equals (opa_i - opb_i) mod 2^WIDTH. For equal operands this gives all zeros.
- R3: With ones_i=0, ovf_o is 1 exactly when the true signed result lies outside [-128, 127]. Operands are read as two's-complement values with bit 7 as the sign.
- R4: With ones_i=1 and sub_i=0, the operands are read as one's-complement values (negative x is stored as ~|x|). When the true sum is non-zero and lies within [-127, 127], res_o holds its one's-complement encoding. The carry-out of bit 7 is added back in at bit 0.
- R5: With ones_i=1 and sub_i=1, the unit computes opa_i + ~opb_i with end-around carry. When the non-zero true difference lies within [-127, 127], res_o holds its one's-complement encoding.
- R6: With ones_i=1, ovf_o is 1 exactly when the true one's-complement result lies outside [-127, 127].
- R7: With ones_i=1, a true result of zero may appear as 8'h00 or as 8'hFF, and ovf_o is 0. Subtracting an operand from itself gives 8'hFF.
- R8: The block is purely combinational: res_o and ovf_o follow a change of the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH (8) | First operand, signed, MSB is the sign |
| opb_i | input | WIDTH (8) | Second operand, signed, MSB is the sign |
| sub_i | input | 1 | 1 = subtract opb_i from opa_i, 0 = add |
| ones_i | input | 1 | 1 = one's-complement arithmetic, 0 = two's-complement |
| res_o | output | WIDTH (8) | Result |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
Both results, res_o and ovf_o, are due in the same cycle as the stimulus because no register lies on any path. The bench therefore changes the inputs and samples 2 ns later, well inside one 20 ns clock period, without waiting for any clock edge. Each operand set is held until its sample has been taken. Every operand pair is swept in all four combinations of operation and mode, and a seeded random phase and directed corner cases are added on top.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    localparam int unsigned ADDSUB_W = 8;

    typedef enum logic {
        MODE_TWOS = 1'b0,
        MODE_ONES = 1'b1
    } cmode_e;

    typedef struct packed {
        logic sub;
        logic wrap;
        logic cin;
    } ctl_t;
endpackage

// File: rtl/addsub_fa.sv
module addsub_fa (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic prop_d;

    always_comb begin
        prop_d = x_i ^ y_i;                    // shared by sum and carry
        s_o    = prop_d ^ c_i;
        c_o    = (x_i & y_i) | (prop_d & c_i);
    end
endmodule

// File: rtl/addsub_chain.sv
module addsub_chain #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         cmsb_o,
    output logic         cout_o
);
    logic [W:0] carry_d;

    assign carry_d[0] = c_i;

    for (genvar k = 0; k < W; k++) begin : g_bit
        addsub_fa u_fa (
            .x_i (x_i[k]),
            .y_i (y_i[k]),
            .c_i (carry_d[k]),
            .s_o (s_o[k]),
            .c_o (carry_d[k+1])
        );
    end

    assign cmsb_o = carry_d[W-1];
    assign cout_o = carry_d[W];
endmodule

// File: rtl/addsub_ovf.sv
module addsub_ovf (
    input  logic xs_i,
    input  logic ys_i,
    input  logic rs_i,
    output logic v_o
);
    always_comb begin
        v_o = ~(xs_i ^ ys_i) & (rs_i ^ xs_i);
    end
endmodule

// File: rtl/addsub_dual.sv
module addsub_dual #(
    parameter int unsigned WIDTH = addsub_pkg::ADDSUB_W
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             sub_i,
    input  logic             ones_i,
    output logic [WIDTH-1:0] res_o,
    output logic             ovf_o
);
    import addsub_pkg::*;

    localparam int unsigned MSB = WIDTH - 1;

    cmode_e           mode_d;
    ctl_t             ctl_d;
    logic [WIDTH-1:0] beff_d;
    logic [WIDTH-1:0] sum1_d;
    logic             cmsb1_d;
    logic             cout1_d;
    logic             cmsb2_d;
    logic             cout2_d;
    logic             wrap_cin_d;

    always_comb begin
        mode_d     = cmode_e'(ones_i);
        ctl_d.sub  = sub_i;
        ctl_d.wrap = (mode_d == MODE_ONES);
        ctl_d.cin  = sub_i & (mode_d == MODE_TWOS);
        beff_d     = opb_i ^ {WIDTH{ctl_d.sub}};
    end

    // main chain: A + (B ^ sub) + cin
    addsub_chain #(.W(WIDTH)) u_main (
        .x_i    (opa_i),
        .y_i    (beff_d),
        .c_i    (ctl_d.cin),
        .s_o    (sum1_d),
        .cmsb_o (cmsb1_d),
        .cout_o (cout1_d)
    );

    assign wrap_cin_d = ctl_d.wrap & cout1_d;

    // end-around carry: second pass adds the carry-out back in at bit 0
    addsub_chain #(.W(WIDTH)) u_wrap (
        .x_i    (sum1_d),
        .y_i    ({WIDTH{1'b0}}),
        .c_i    (wrap_cin_d),
        .s_o    (res_o),
        .cmsb_o (cmsb2_d),
        .cout_o (cout2_d)
    );

    addsub_ovf u_ovf (
        .xs_i (opa_i[MSB]),
        .ys_i (beff_d[MSB]),
        .rs_i (res_o[MSB]),
        .v_o  (ovf_o)
    );

    always_comb begin
        // R3: sign-based overflow agrees with the carry-pair overflow of the main chain
        if (!ones_i) begin
            a_r3_ovf_carry_pair: assert (ovf_o == (cmsb1_d ^ cout1_d));
        end
        // R4: the end-around pass can never carry out of the top bit
        a_r4_no_second_carry: assert (!cout2_d);
        // R4: a carry into the top bit of the second pass means the lower bits wrapped to zero
        if (cmsb2_d) begin
            a_r4_wrap_low_zero: assert (res_o[MSB-1:0] == '0);
        end
        // R2: x - x in two's-complement is zero without overflow
        if (!ones_i && sub_i && (opa_i == opb_i)) begin
            a_r2_self_zero: assert (res_o == '0 && !ovf_o);
        end
        // R7: x - x in one's-complement is the all-ones zero
        if (ones_i && sub_i && (opa_i == opb_i)) begin
            a_r7_self_ones: assert (res_o == '1 && !ovf_o);
        end
        // R1: adding zero in two's-complement returns the first operand
        if (!ones_i && !sub_i && (opb_i == '0)) begin
            a_r1_add_zero: assert (res_o == opa_i && !ovf_o);
        end
    end
endmodule

// File: tb/tb_addsub_dual.sv
module tb_addsub_dual;
    logic       clk = 1'b0;
    logic [7:0] a = '0;
    logic [7:0] b = '0;
    logic       sub = 1'b0;
    logic       ones = 1'b0;
    logic [7:0] res;
    logic       ovf;
    int         n_chk = 0;
    int         n_err = 0;
    bit         timed_out = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    addsub_dual dut (
        .opa_i (a),
        .opb_i (b),
        .sub_i (sub),
        .ones_i(ones),
        .res_o (res),
        .ovf_o (ovf)
    );

    function automatic int val_twos(logic [7:0] x);
        return x[7] ? int'(x) - 256 : int'(x);
    endfunction

    function automatic int val_ones(logic [7:0] x);
        logic [7:0] m;
        m = ~x;
        return x[7] ? -int'(m) : int'(x);
    endfunction

    function automatic logic [7:0] enc_ones(int t);
        logic [7:0] m;
        m = 8'(t < 0 ? -t : t);
        return (t < 0) ? ~m : m;
    endfunction

    task automatic note(bit ok, string rq, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s a=%02h b=%02h sub=%0d ones=%0d actual=%0h expected=%0h",
                     rq, a, b, sub, ones, act, exp);
        end
    endtask

    task automatic apply(logic [7:0] xa, logic [7:0] xb, logic s, logic o);
        int  t;
        bit  ev;
        logic [7:0] er;
        a = xa; b = xb; sub = s; ones = o;
        #2;   // combinational: sampled before any clock edge (R8)
        if (!o) begin
            t  = s ? val_twos(xa) - val_twos(xb) : val_twos(xa) + val_twos(xb);
            er = 8'(t);
            ev = (t > 127) || (t < -128);
            note(res == er, s ? "R2" : "R1", int'(res), int'(er));
            note(ovf == ev, "R3", int'(ovf), int'(ev));
        end else begin
            t  = s ? val_ones(xa) - val_ones(xb) : val_ones(xa) + val_ones(xb);
            ev = (t > 127) || (t < -127);
            note(ovf == ev, "R6", int'(ovf), int'(ev));
            if (!ev) begin
                if (t == 0) begin
                    note(res == 8'h00 || res == 8'hFF, "R7", int'(res), 0);
                end else begin
                    er = enc_ones(t);
                    note(res == er, s ? "R5" : "R4", int'(res), int'(er));
                end
            end
        end
    endtask

    task automatic run_all();
        int unsigned r;
        // reset-like state: all inputs zero
        #2;
        note(res == 8'h00 && ovf == 1'b0, "R1", int'(res), 0);
        // directed corners
        apply(8'h7F, 8'h01, 1'b0, 1'b0);   // R3 positive overflow
        note(ovf == 1'b1, "R3", int'(ovf), 1);
        apply(8'h80, 8'h01, 1'b1, 1'b0);   // R3 negative overflow
        note(ovf == 1'b1, "R3", int'(ovf), 1);
        apply(8'h5A, 8'h5A, 1'b1, 1'b1);   // R7 self subtract gives FF
        note(res == 8'hFF, "R7", int'(res), 8'hFF);
        apply(8'h05, 8'hFC, 1'b0, 1'b1);   // R4 end-around: 5 + (-3) = 2
        note(res == 8'h02, "R4", int'(res), 2);
        apply(8'h7F, 8'h7F, 1'b0, 1'b1);   // R6 overflow
        note(ovf == 1'b1, "R6", int'(ovf), 1);
        apply(8'h33, 8'h10, 1'b1, 1'b0);   // R8 instant change, R2 value
        note(res == 8'h23, "R8", int'(res), 8'h23);
        // exhaustive sweep, all four operation/mode pairs
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 256; i++) begin
                for (int j = 0; j < 256; j++) begin
                    apply(8'(i), 8'(j), m[0], m[1]);
                end
            end
        end
        // seeded random mix
        r = $urandom(32'd1234);
        for (int k = 0; k < 2000; k++) begin
            r = $urandom;
            apply(r[7:0], r[15:8], r[16], r[17]);
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule